// File: doc/BRIEF.md
# Device Enumeration Table Walker

This block scans a 64-word device identification table. It starts at index 0 and reads one word per entry through a simple synchronous read port. The port drives an address with a read strobe, and the word comes back on the next cycle. Each word carries a type code in its two low bits and a continuation flag in its top bit. Consecutive valid words that are joined by the continuation flag describe one device. The walker decodes each word by its type and merges the decoded fields into one device record. When the last word of a device is reached, it offers the record on a valid/ready output.

A record holds the following:
- the engine, runlist, interrupt, reset and fault identifiers, each with its own valid flag;
- the instance number;
- the engine type code with its flag;
- the byte base address of the device registers.

For engine types that share one base across several instances, the base is offset by a parameterised stride times the instance number. While the walk runs, the block checks the table for consistency and raises sticky error flags. A one-cycle done pulse closes the walk. All flags are final when that pulse is seen.

Top module: `devtab_walker`

## Requirements
- R1: After reset, `recValid`, `done`, `tblRd` and all five error flags are 0.
- R2: A `start` pulse while idle reads table addresses 0 to 63 once each, in increasing order. Each read is followed by at least one cycle without a read. After the last word is processed, `done` is high for exactly one cycle.
- R3: A word whose type code (bits 1:0) is 0 is ignored completely, including its bit 31. A valid word (type 1, 2 or 3) joins the open record. A valid word with bit 31 = 0 closes the record, and exactly one record is emitted per close.
- R4: A type-2 (enumeration) word sets four identifiers, each with a valid flag: engine id from bits 29:26 (flag bit 5), runlist id from bits 24:21 (flag bit 4), interrupt id from bits 19:15 (flag bit 3) and reset id from bits 13:9 (flag bit 2). Any identifier whose flag is 0 is output as 0.
- R5: A type-1 (data) word sets the instance id from bits 29:26 (default 0 if absent) and the fault id from bits 9:3 (flag bit 2, output 0 when clear). It also sets the base address, which is the word masked to bits 23:12.
- R6: The base is raised by `INST_STRIDE` × instance id when three conditions hold: the record has a type code, that code is below 32, and bit `code` of `SHARED_TYPES` is set. The defaults are a stride of 0x1000 and code 19 as the only shared type.
- R7: A type-3 word sets `recTypeVld` and the 29-bit type code from bits 30:2.
- R8: While `recValid` is high and `recReady` is low, the record fields stay stable, `recValid` stays high, and no table read is issued.
- R9: A record accepted with a valid engine id that an earlier accepted record already carried sets `errDupEngine`.
- R10: If any engine id 0 to `NUM_ENGINES`-1 was never accepted, `errMissingEngine` is set before `done` is raised.
- R11: A record accepted without any type-1 word sets `errNoData`.
- R12: If a record is still open after word 63, it is emitted anyway and `errChainEnd` is set while it is offered.
- R13: A type-1 word with bit 30 set raises `errDataFmt`.
- R14: A `start` pulse during a walk is ignored. A `start` pulse while idle clears all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (used only while idle) |
| tblRd | output | 1 | Table read strobe |
| tblAddr | output | 6 | Table word index |
| tblData | input | 32 | Table word, valid the cycle after `tblRd` |
| recValid | output | 1 | Record offered |
| recReady | input | 1 | Record accepted |
| recEngineVld | output | 1 | Engine id valid |
| recEngineId | output | 4 | Engine id |
| recRunlistVld | output | 1 | Runlist id valid |
| recRunlistId | output | 4 | Runlist id |
| recIntrVld | output | 1 | Interrupt id valid |
| recIntrId | output | 5 | Interrupt id |
| recResetVld | output | 1 | Reset id valid |
| recResetId | output | 5 | Reset id |
| recFaultVld | output | 1 | Fault id valid |
| recFaultId | output | 7 | Fault id |
| recInstId | output | 4 | Instance id |
| recTypeVld | output | 1 | Type code present |
| recTypeCode | output | 29 | Engine type code |
| recBaseAddr | output | 32 | Byte base address, instanced where shared |
| done | output | 1 | One-cycle end-of-walk pulse |
| errDupEngine | output | 1 | Duplicate engine id seen |
| errMissingEngine | output | 1 | Required engine id absent |
| errNoData | output | 1 | Device without data word |
| errChainEnd | output | 1 | Record still open after last word |
| errDataFmt | output | 1 | Data word with bit 30 set |

## Verification
Several kinds of faulty internal state show up at the ports, each at a known time:
- A wrong entry index shows at `tblAddr` on the very next read, and the bench compares every read address against a running count.
- A record register that is not cleared between devices leaks old fields into the next record. This is visible as soon as that record raises `recValid`.
- A corrupted seen-engine vector shows as a wrong duplicate flag one cycle after the handshake, or as a wrong missing flag at `done`.
- A broken stall path issues a read or changes a field during a held handshake, within the first stalled cycle.

// File: rtl/devtab_pkg.sv
package devtab_pkg;
  localparam int WORD_W   = 32;
  localparam int ENG_W    = 4;
  localparam int RUN_W    = 4;
  localparam int INTR_W   = 5;
  localparam int RST_W    = 5;
  localparam int FAULT_W  = 7;
  localparam int INST_W   = 4;
  localparam int TYPE_W   = 29;

  typedef enum logic [1:0] {
    KIND_SKIP = 2'd0,
    KIND_DATA = 2'd1,
    KIND_ENUM = 2'd2,
    KIND_TYPE = 2'd3
  } entryKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic loadEntry;
    logic acceptRec;
    logic flagChainEnd;
    logic checkDone;
  } walkCtl_t;
endpackage

// File: rtl/devtab_ctrl.sv
module devtab_ctrl
  import devtab_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             entryChain,
  input  logic [1:0]       entryKind,
  input  logic             recReady,
  output logic             tblRd,
  output logic [IDX_W-1:0] tblAddr,
  output logic             recValid,
  output logic             done,
  output walkCtl_t         ctl
);
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_DECODE, S_EMIT, S_CHECK, S_DONE
  } state_e;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

  state_e stateQ, stateN;
  logic [IDX_W-1:0] idxQ, idxN;
  logic openQ, openN;
  logic lastEntry, validKind;

  assign lastEntry = (idxQ == LAST_IDX);
  assign validKind = (entryKind != KIND_SKIP);

  always_comb begin
    stateN = stateQ;
    idxN   = idxQ;
    openN  = openQ;
    ctl    = '0;
    case (stateQ)
      S_IDLE: if (start) begin
        ctl.clearAll = 1'b1;
        idxN   = '0;
        openN  = 1'b0;
        stateN = S_ISSUE;
      end
      S_ISSUE: stateN = S_DECODE;
      S_DECODE: begin
        if (validKind) begin
          ctl.loadEntry = 1'b1;
          openN = 1'b1;
        end
        if (validKind && !entryChain) begin
          stateN = S_EMIT;
        end else if (lastEntry) begin
          if (openQ || validKind) begin
            ctl.flagChainEnd = 1'b1;
            stateN = S_EMIT;
          end else begin
            stateN = S_CHECK;
          end
        end else begin
          idxN   = idxQ + 1'b1;
          stateN = S_ISSUE;
        end
      end
      S_EMIT: if (recReady) begin
        ctl.acceptRec = 1'b1;
        openN = 1'b0;
        if (lastEntry) stateN = S_CHECK;
        else begin
          idxN   = idxQ + 1'b1;
          stateN = S_ISSUE;
        end
      end
      S_CHECK: begin
        ctl.checkDone = 1'b1;
        stateN = S_DONE;
      end
      S_DONE:  stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= S_IDLE;
      idxQ   <= '0;
      openQ  <= 1'b0;
    end else begin
      stateQ <= stateN;
      idxQ   <= idxN;
      openQ  <= openN;
    end
  end

  assign tblRd    = (stateQ == S_ISSUE);
  assign tblAddr  = idxQ;
  assign recValid = (stateQ == S_EMIT);
  assign done     = (stateQ == S_DONE);

  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tblRd |=> !tblRd);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && !recReady) |=> (recValid && $stable(tblAddr)));
  assert_no_read_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    recValid |-> !tblRd);
endmodule

// File: rtl/devtab_datapath.sv
module devtab_datapath
  import devtab_pkg::*;
#(
  parameter int          NUM_ENGINES  = 4,
  parameter logic [31:0] INST_STRIDE  = 32'h0000_1000,
  parameter logic [31:0] SHARED_TYPES = 32'h0008_0000,
  localparam int ENG_SLOTS = 1 << ENG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  walkCtl_t           ctl,
  input  logic [WORD_W-2:0]  entry,
  output logic               recEngineVld,
  output logic [ENG_W-1:0]   recEngineId,
  output logic               recRunlistVld,
  output logic [RUN_W-1:0]   recRunlistId,
  output logic               recIntrVld,
  output logic [INTR_W-1:0]  recIntrId,
  output logic               recResetVld,
  output logic [RST_W-1:0]   recResetId,
  output logic               recFaultVld,
  output logic [FAULT_W-1:0] recFaultId,
  output logic [INST_W-1:0]  recInstId,
  output logic               recTypeVld,
  output logic [TYPE_W-1:0]  recTypeCode,
  output logic [WORD_W-1:0]  recBaseAddr,
  output logic               errDupEngine,
  output logic               errMissingEngine,
  output logic               errNoData,
  output logic               errChainEnd,
  output logic               errDataFmt
);
  logic [11:0] priBaseQ;
  logic hasDataQ;
  logic [ENG_SLOTS-1:0] seenQ;
  logic sharedType;
  logic [WORD_W-1:0] instOffset;
  entryKind_e kind;

  assign kind = entryKind_e'(entry[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {recEngineVld, recEngineId, recRunlistVld, recRunlistId} <= '0;
      {recIntrVld, recIntrId, recResetVld, recResetId}         <= '0;
      {recFaultVld, recFaultId, recInstId, recTypeVld}         <= '0;
      recTypeCode <= '0;
      priBaseQ    <= '0;
      hasDataQ    <= 1'b0;
    end else if (ctl.clearAll || ctl.acceptRec) begin
      {recEngineVld, recEngineId, recRunlistVld, recRunlistId} <= '0;
      {recIntrVld, recIntrId, recResetVld, recResetId}         <= '0;
      {recFaultVld, recFaultId, recInstId, recTypeVld}         <= '0;
      recTypeCode <= '0;
      priBaseQ    <= '0;
      hasDataQ    <= 1'b0;
    end else if (ctl.loadEntry) begin
      case (kind)
        KIND_ENUM: begin
          recEngineVld  <= entry[5];
          recEngineId   <= entry[5] ? entry[29:26] : '0;
          recRunlistVld <= entry[4];
          recRunlistId  <= entry[4] ? entry[24:21] : '0;
          recIntrVld    <= entry[3];
          recIntrId     <= entry[3] ? entry[19:15] : '0;
          recResetVld   <= entry[2];
          recResetId    <= entry[2] ? entry[13:9] : '0;
        end
        KIND_DATA: begin
          recInstId   <= entry[29:26];
          priBaseQ    <= entry[23:12];
          recFaultVld <= entry[2];
          recFaultId  <= entry[2] ? entry[9:3] : '0;
          hasDataQ    <= 1'b1;
        end
        KIND_TYPE: begin
          recTypeVld  <= 1'b1;
          recTypeCode <= entry[30:2];
        end
        default: ;
      endcase
    end
  end

  // error tracking and engine bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenQ <= '0;
      {errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt} <= '0;
    end else if (ctl.clearAll) begin
      seenQ <= '0;
      {errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt} <= '0;
    end else begin
      if (ctl.loadEntry && kind == KIND_DATA && entry[30]) errDataFmt <= 1'b1;
      if (ctl.flagChainEnd) errChainEnd <= 1'b1;
      if (ctl.acceptRec) begin
        if (!hasDataQ) errNoData <= 1'b1;
        if (recEngineVld) begin
          if (seenQ[recEngineId]) errDupEngine <= 1'b1;
          seenQ[recEngineId] <= 1'b1;
        end
      end
      if (ctl.checkDone && !(&seenQ[NUM_ENGINES-1:0])) errMissingEngine <= 1'b1;
    end
  end

  assign sharedType = recTypeVld && (recTypeCode[TYPE_W-1:5] == '0)
                      && SHARED_TYPES[recTypeCode[4:0]];
  assign instOffset = sharedType ? INST_STRIDE * WORD_W'(recInstId) : '0;
  assign recBaseAddr = {8'h00, priBaseQ, 12'h000} + instOffset;

  assert_id_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!recEngineVld |-> recEngineId == '0) and (!recIntrVld |-> recIntrId == '0));
  assert_sticky_dup_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (errDupEngine && !ctl.clearAll) |=> errDupEngine);
  assert_sticky_missing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (errMissingEngine && !ctl.clearAll) |=> errMissingEngine);
endmodule

// File: rtl/devtab_walker.sv
module devtab_walker
  import devtab_pkg::*;
#(
  parameter int          NUM_ENTRIES  = 64,
  parameter int          NUM_ENGINES  = 4,
  parameter logic [31:0] INST_STRIDE  = 32'h0000_1000,
  parameter logic [31:0] SHARED_TYPES = 32'h0008_0000,
  localparam int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               tblRd,
  output logic [IDX_W-1:0]   tblAddr,
  input  logic [WORD_W-1:0]  tblData,
  output logic               recValid,
  input  logic               recReady,
  output logic               recEngineVld,
  output logic [ENG_W-1:0]   recEngineId,
  output logic               recRunlistVld,
  output logic [RUN_W-1:0]   recRunlistId,
  output logic               recIntrVld,
  output logic [INTR_W-1:0]  recIntrId,
  output logic               recResetVld,
  output logic [RST_W-1:0]   recResetId,
  output logic               recFaultVld,
  output logic [FAULT_W-1:0] recFaultId,
  output logic [INST_W-1:0]  recInstId,
  output logic               recTypeVld,
  output logic [TYPE_W-1:0]  recTypeCode,
  output logic [WORD_W-1:0]  recBaseAddr,
  output logic               done,
  output logic               errDupEngine,
  output logic               errMissingEngine,
  output logic               errNoData,
  output logic               errChainEnd,
  output logic               errDataFmt
);
  walkCtl_t ctl;

  devtab_ctrl #(.NUM_ENTRIES(NUM_ENTRIES)) ctrl_i (
    .clk, .rst_n, .start,
    .entryChain(tblData[31]), .entryKind(tblData[1:0]),
    .recReady, .tblRd, .tblAddr, .recValid, .done, .ctl
  );

  devtab_datapath #(
    .NUM_ENGINES(NUM_ENGINES), .INST_STRIDE(INST_STRIDE), .SHARED_TYPES(SHARED_TYPES)
  ) dp_i (
    .clk, .rst_n, .ctl, .entry(tblData[30:0]),
    .recEngineVld, .recEngineId, .recRunlistVld, .recRunlistId,
    .recIntrVld, .recIntrId, .recResetVld, .recResetId,
    .recFaultVld, .recFaultId, .recInstId, .recTypeVld, .recTypeCode,
    .recBaseAddr, .errDupEngine, .errMissingEngine, .errNoData,
    .errChainEnd, .errDataFmt
  );

  assert_record_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && !recReady) |=> ($stable(recBaseAddr) && $stable(recEngineId)
                                 && $stable(recTypeCode) && $stable(recFaultId)));
endmodule

// File: tb/devtab_walker_tb_top.sv
module devtab_walker_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, recReady = 1'b0;
  logic tblRd, recValid, done;
  logic [5:0] tblAddr;
  logic [31:0] tblData = '0;
  logic recEngineVld, recRunlistVld, recIntrVld, recResetVld, recFaultVld, recTypeVld;
  logic [3:0] recEngineId, recRunlistId, recInstId;
  logic [4:0] recIntrId, recResetId;
  logic [6:0] recFaultId;
  logic [28:0] recTypeCode;
  logic [31:0] recBaseAddr;
  logic errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt;

  always #2.5 clk = ~clk;  // 200 MHz

  devtab_walker dut_i (.*);

  typedef struct packed {
    logic ev; logic [3:0] e; logic rv; logic [3:0] r;
    logic iv; logic [4:0] i; logic sv; logic [4:0] s;
    logic fv; logic [6:0] f; logic [3:0] inst;
    logic tv; logic [28:0] t; logic [31:0] base;
  } rec_t;

  // expected records for the well-formed table
  localparam rec_t EXP_A [4] = '{
    '{1'b1,4'd0, 1'b1,4'd0, 1'b1,5'd5,  1'b1,5'd3, 1'b1,7'h10, 4'd0, 1'b1,29'd0,  32'h0040_0000},
    '{1'b1,4'd1, 1'b1,4'd1, 1'b0,5'd0,  1'b1,5'd4, 1'b0,7'h00, 4'd2, 1'b1,29'd19, 32'h0012_5000},
    '{1'b1,4'd2, 1'b0,4'd0, 1'b1,5'd31, 1'b0,5'd0, 1'b1,7'h7F, 4'd3, 1'b0,29'd0,  32'h00FF_F000},
    '{1'b1,4'd3, 1'b1,4'd2, 1'b0,5'd0,  1'b0,5'd0, 1'b0,7'h00, 4'd1, 1'b1,29'd1,  32'h0001_0000}
  };

  logic [31:0] tbl [64];
  int checks = 0, failures = 0, cycles = 0;
  int expIdx = 0, addrErr = 0, stallReads = 0, recCount = 0;

  always @(posedge clk) if (tblRd) tblData <= tbl[tblAddr];

  always @(negedge clk) begin
    if (tblRd) begin
      if (tblAddr != expIdx[5:0]) addrErr++;
      expIdx++;
    end
    if (tblRd && recValid) stallReads++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkEnum(bit c, bit ev, int e, bit rv, int r,
                                         bit iv, int i, bit sv, int s);
    return {c, 1'b0, 4'(e), 1'b0, 4'(r), 1'b0, 5'(i), 1'b0, 5'(s), 3'b0, ev, rv, iv, sv, 2'd2};
  endfunction
  function automatic logic [31:0] mkData(bit c, bit fmt, int inst, int base, bit fv, int f);
    return {c, fmt, 4'(inst), 2'b0, 12'(base), 2'b0, 7'(f), fv, 2'd1};
  endfunction
  function automatic logic [31:0] mkType(bit c, int code);
    return {c, 29'(code), 2'd3};
  endfunction

  task automatic buildA();
    foreach (tbl[k]) tbl[k] = '0;
    tbl[0]  = mkType(1, 0);
    tbl[1]  = mkEnum(1, 1,0, 1,0, 1,5, 1,3);
    tbl[2]  = mkData(0, 0, 0, 12'h400, 1, 7'h10);
    tbl[3]  = 32'hFFFF_FFFC;                      // skipped, chain bit set
    tbl[4]  = mkType(1, 19);
    tbl[5]  = 32'h0000_0000;                      // skipped, chain bit clear
    tbl[6]  = mkEnum(1, 1,1, 1,1, 0,7, 1,4);
    tbl[7]  = mkData(0, 0, 2, 12'h123, 0, 7'h55);
    tbl[8]  = mkEnum(1, 1,2, 0,9, 1,31, 0,17);
    tbl[9]  = mkData(0, 0, 3, 12'hFFF, 1, 7'h7F);
    tbl[10] = mkData(1, 0, 1, 12'h010, 0, 0);
    tbl[11] = mkEnum(1, 1,3, 1,2, 0,0, 0,0);
    tbl[12] = mkType(0, 1);
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitRec();
    int n = 0;
    while (!recValid && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic acceptRec();
    recReady = 1'b1;
    @(negedge clk);
    recReady = 1'b0;
    recCount++;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, tag, 64'(done), 64'd1);
    @(negedge clk);
    check(!done, tag, 64'(done), 64'd0);  // R2 single-cycle pulse
  endtask

  task automatic runA(input string pass);
    rec_t got;
    buildA();
    expIdx = 0; addrErr = 0; recCount = 0;
    pulseStart();
    check({errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt} == 0,
          "R14 errors cleared by start", 64'({errDupEngine, errMissingEngine, errNoData,
          errChainEnd, errDataFmt}), 64'd0);
    for (int k = 0; k < 4; k++) begin
      waitRec();
      got = '{recEngineVld, recEngineId, recRunlistVld, recRunlistId, recIntrVld, recIntrId,
              recResetVld, recResetId, recFaultVld, recFaultId, recInstId, recTypeVld,
              recTypeCode, recBaseAddr};
      check(recValid, "R3 record offered", 64'(recValid), 64'd1);
      check({got.ev,got.e,got.rv,got.r,got.iv,got.i,got.sv,got.s} ==
            {EXP_A[k].ev,EXP_A[k].e,EXP_A[k].rv,EXP_A[k].r,EXP_A[k].iv,EXP_A[k].i,EXP_A[k].sv,EXP_A[k].s},
            "R4 enum ids", 64'({got.ev,got.e,got.rv,got.r,got.iv,got.i,got.sv,got.s}),
            64'({EXP_A[k].ev,EXP_A[k].e,EXP_A[k].rv,EXP_A[k].r,EXP_A[k].iv,EXP_A[k].i,EXP_A[k].sv,EXP_A[k].s}));
      check({got.fv,got.f,got.inst} == {EXP_A[k].fv,EXP_A[k].f,EXP_A[k].inst}, "R5 data fields",
            64'({got.fv,got.f,got.inst}), 64'({EXP_A[k].fv,EXP_A[k].f,EXP_A[k].inst}));
      check(got.base == EXP_A[k].base, (k == 1) ? "R6 instanced base" : "R5 base",
            64'(got.base), 64'(EXP_A[k].base));
      check({got.tv,got.t} == {EXP_A[k].tv,EXP_A[k].t}, "R7 type code",
            64'({got.tv,got.t}), 64'({EXP_A[k].tv,EXP_A[k].t}));
      acceptRec();
    end
    waitDone({"R2 done ", pass});
    check(recCount == 4 && !recValid, "R3 record count", 64'(recCount), 64'd4);
    check(addrErr == 0 && expIdx == 64, "R2 address order", 64'(expIdx), 64'd64);
    check({errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt} == 0,
          "R10 clean table has no errors", 64'({errDupEngine, errMissingEngine, errNoData,
          errChainEnd, errDataFmt}), 64'd0);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    failures++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!recValid && !done && !tblRd, "R1 reset outputs", 64'({recValid, done, tblRd}), 64'd0);
    check({errDupEngine, errMissingEngine, errNoData, errChainEnd, errDataFmt} == 0,
          "R1 reset errors", 64'({errDupEngine, errMissingEngine, errNoData, errChainEnd,
          errDataFmt}), 64'd0);

    runA("first");

    // error table
    foreach (tbl[k]) tbl[k] = '0;
    tbl[0]  = mkEnum(0, 1,1, 0,0, 0,0, 0,0);
    tbl[1]  = mkEnum(1, 1,1, 0,0, 0,0, 0,0);
    tbl[2]  = mkData(0, 1, 0, 12'h001, 0, 0);
    tbl[63] = mkType(1, 5);
    expIdx = 0; addrErr = 0; stallReads = 0;
    pulseStart();
    waitRec();
    check(!errNoData, "R11 not before accept", 64'(errNoData), 64'd0);
    begin
      logic [31:0] b0 = recBaseAddr;
      logic [5:0] a0 = tblAddr;
      bit held = 1'b1;
      repeat (5) begin
        @(negedge clk);
        if (!recValid || recBaseAddr != b0 || tblAddr != a0) held = 1'b0;
      end
      check(held && stallReads == 0, "R8 stall holds", 64'({held, 8'(stallReads)}), 64'h100);
    end
    acceptRec();
    check(errNoData && !errDupEngine, "R11 no data entry", 64'({errNoData, errDupEngine}), 64'b10);
    start = 1'b1; @(negedge clk); start = 1'b0;  // R14 ignored while busy
    waitRec();
    check(errDataFmt, "R13 data format bit", 64'(errDataFmt), 64'd1);
    check(recBaseAddr == 32'h0000_1000, "R5 base with format bit", 64'(recBaseAddr), 64'h1000);
    acceptRec();
    check(errDupEngine, "R9 duplicate engine", 64'(errDupEngine), 64'd1);
    waitRec();
    check(errChainEnd && recTypeVld && recTypeCode == 29'd5, "R12 open chain at end",
          64'({errChainEnd, recTypeVld, recTypeCode}), 64'({1'b1, 1'b1, 29'd5}));
    check(!errMissingEngine, "R10 not before done", 64'(errMissingEngine), 64'd0);
    acceptRec();
    begin
      int n = 0;
      while (!done && n < 100) begin @(negedge clk); n++; end
    end
    check(done && errMissingEngine, "R10 missing engine at done",
          64'({done, errMissingEngine}), 64'b11);
    @(negedge clk);
    check(addrErr == 0 && expIdx == 64, "R14 walk not restarted", 64'(expIdx), 64'd64);

    runA("second");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule